// File: doc/BRIEF.md
# Shift-on-Read Register FIFO

This block is a small synchronous first-in first-out buffer made only of flip-flops. It has no read pointer. The read data always comes from one fixed register at the head of a chain. When an entry is popped, every stored entry moves one register closer to the head. A single occupancy counter, which can count up or down, chooses the register that takes the next write.

Removing the read pointer also removes the wide read multiplexer that goes with it. The cost is that a pop clocks every register in the chain. The block suits shallow, narrow queues where area matters more than switching activity. A push and a pop may be issued in the same cycle. The depth and the data width are parameters, with defaults of 29 entries of 6 bits.

Top module: `shfifo`

## Requirements
- R1: While rst_n is low, and at the first edge after it is released, empty reads 1 and full reads 0. The stored contents are not cleared.
- R2: Whenever empty is 0, rd_data shows the oldest stored entry. Entries leave in the order they were pushed. After an accepted pop, the next entry appears on rd_data one clock edge later.
- R3: A cycle with push high and pop low, while full is 0, stores wr_data behind the last entry and raises the occupancy by one.
- R4: A cycle with pop high and push low, while empty is 0, removes the head entry and lowers the occupancy by one.
- R5: A cycle with push and pop both high, while the FIFO is neither empty nor full, removes the head and appends wr_data. The occupancy is unchanged.
- R6: A cycle with push and pop both high while empty is 1 ignores the pop and stores wr_data. The FIFO then holds exactly that entry.
- R7: A push with pop low while full is 1 is ignored. The contents, their order and full are unchanged.
- R8: A pop with push low while empty is 1 is ignored. The FIFO stays empty and a later push is the only entry.
- R9: A cycle with push and pop both high while full is 1 accepts both. The head leaves, wr_data is appended, and full stays 1.
- R10: empty is 1 exactly when the occupancy is zero. full is 1 exactly when the occupancy equals DEPTH. Both follow the occupancy within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, releases synchronously |
| push | input | 1 | Write request |
| wr_data | input | WIDTH | Data to store |
| pop | input | 1 | Read request, which removes the head entry |
| rd_data | output | WIDTH | Head entry |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |

## Verification
The bench first walks through directed sequences:
- filling to full, pushing into a full FIFO, and a simultaneous push and pop while full;
- draining to empty, popping an empty FIFO, and a simultaneous push and pop while empty.

These separate the guarded cases from the ordinary shift and append. A random phase follows. It biases toward filling, then toward draining, so that partial occupancies mix all four push/pop combinations. A reference queue held in the bench detects ordering slips, lost or duplicated entries, and off-by-one write slots.

// File: rtl/shfifo_pkg.sv
package shfifo_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_BOTH = 2'b11
  } fifo_op_e;
endpackage

// File: rtl/shfifo_ctrl.sv
module shfifo_ctrl #(
  parameter int DEPTH = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [DEPTH-1:0] wsel,
  output logic             shift,
  output logic             full,
  output logic             empty
);
  import shfifo_pkg::*;
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q, cnt_d, widx;
  logic          wr_ok, cnt_en;
  fifo_op_e      op;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign shift = pop && !empty;
  assign wr_ok = push && (!full || pop);
  assign op    = fifo_op_e'({shift, wr_ok});
  assign widx  = shift ? cnt_q - 1'b1 : cnt_q;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    case (op)
      OP_PUSH: begin cnt_d = cnt_q + 1'b1; cnt_en = 1'b1; end
      OP_POP:  begin cnt_d = cnt_q - 1'b1; cnt_en = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_sel
    assign wsel[i] = wr_ok && (widx == CW'(i));
  end

  p_count_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  p_push_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !full) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_pop_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !empty) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_both_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty) |=> $stable(cnt_q));
  p_both_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && empty) |=> (cnt_q == CW'(1)));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && full) |=> full);
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> empty);
endmodule

// File: rtl/shfifo_slot.sv
module shfifo_slot #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wsel,
  input  logic             shift,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] behind,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] d;
  logic             en;

  assign en = wsel || shift;

  always_comb begin
    d = q;
    if (wsel)       d = wr_data;
    else if (shift) d = behind;
  end

  always_ff @(posedge clk) begin
    if (en) q <= d;
  end

  p_slot_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wsel && !shift) |=> $stable(q));
  p_slot_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wsel |=> (q == $past(wr_data)));
endmodule

// File: rtl/shfifo.sv
module shfifo #(
  parameter int DEPTH = 29,
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty
);
  logic [DEPTH-1:0]            wsel;
  logic                        shift;
  logic [DEPTH-1:0][WIDTH-1:0] slot_q;

  shfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wsel(wsel), .shift(shift), .full(full), .empty(empty)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_chain
    logic [WIDTH-1:0] behind;
    if (i == DEPTH - 1) begin : g_tail
      assign behind = slot_q[i];
    end else begin : g_mid
      assign behind = slot_q[i+1];
    end
    shfifo_slot #(.WIDTH(WIDTH)) u_slot (
      .clk(clk), .rst_n(rst_n), .wsel(wsel[i]), .shift(shift),
      .wr_data(wr_data), .behind(behind), .q(slot_q[i])
    );
  end

  assign rd_data = slot_q[0];

  p_head_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !$past(full) && !full && !wsel[0]) |=> (rd_data == $past(slot_q[1])));
endmodule

// File: tb/tb_shfifo.sv
`timescale 1ns/1ps
module tb_shfifo;
  localparam int DEPTH = 29;
  localparam int WIDTH = 6;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             push, pop;
  logic [WIDTH-1:0] wr_data;
  logic [WIDTH-1:0] rd_data;
  logic             full, empty;

  int n_checks = 0;
  int n_fail   = 0;
  logic [WIDTH-1:0] model [$];

  always #2.5 clk = ~clk;

  shfifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk(clk), .rst_n(rst_n), .push(push), .wr_data(wr_data),
    .pop(pop), .rd_data(rd_data), .full(full), .empty(empty)
  );

  function automatic string op_tag(bit p, bit q, int n);
    if (p && q && n == 0)      return "R6";
    if (p && q && n == DEPTH)  return "R9";
    if (p && q)                return "R5";
    if (p && n == DEPTH)       return "R7";
    if (p)                     return "R3";
    if (q && n == 0)           return "R8";
    if (q)                     return "R4";
    return "R2";
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_state(string tag);
    check("R10", "empty", int'(empty), int'(model.size() == 0));
    check("R10", "full", int'(full), int'(model.size() == DEPTH));
    if (model.size() > 0) check(tag, "rd_data", int'(rd_data), int'(model[0]));
  endtask

  task automatic step(bit p, bit q, logic [WIDTH-1:0] d);
    string tag;
    int    n;
    @(negedge clk);
    push = p; pop = q; wr_data = d;
    n   = model.size();
    tag = op_tag(p, q, n);
    @(posedge clk);
    if (q && n > 0) void'(model.pop_front());
    if (p && (n < DEPTH || (q && n > 0))) model.push_back(d);
    #1;
    check_state(tag);
  endtask

  initial begin
    #400000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    push = 0; pop = 0; wr_data = '0;
    rst_n = 1'b0;
    #1;
    check("R1", "empty in reset", int'(empty), 1);
    check("R1", "full in reset", int'(full), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", "empty after reset", int'(empty), 1);
    check("R1", "full after reset", int'(full), 0);

    step(0, 1, 6'h11);                          // R8 pop empty
    step(1, 1, 6'h2a);                          // R6 both empty
    step(0, 1, 6'h00);                          // drain to empty
    for (int i = 0; i < DEPTH; i++) step(1, 0, WIDTH'(i + 3));
    step(1, 0, 6'h3f);                          // R7 push full
    step(1, 0, 6'h3e);
    step(1, 1, 6'h15);                          // R9 both full
    step(1, 1, 6'h16);
    step(0, 0, 6'h00);                          // R2 idle hold
    for (int i = 0; i < DEPTH + 2; i++) step(0, 1, 6'h00);   // R4, then R8
    for (int i = 0; i < 5; i++) step(1, 0, WIDTH'(40 + i));
    for (int i = 0; i < 8; i++) step(1, 1, WIDTH'(50 + i)); // R5

    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 300; i++) begin
        int pw = (r % 2 == 0) ? 70 : 30;
        step(($urandom % 100) < pw, ($urandom % 100) < (100 - pw),
             WIDTH'($urandom));
      end
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule